// File: doc/BRIEF.md
# Cascadable TDM Stereo Output Serializer

This block turns one stereo sample pair into a serial bit stream for a time-division-multiplexed output line. Several copies can feed one host serial port. When a frame-sync pulse is seen on the bit clock, the block copies its left and right words into a 64-bit shift register. After that the register shifts one bit toward the serial output on every bit clock.

The bit that enters the bottom of the register comes from a cascade input, not from a constant. When the serial output of one copy drives the cascade input of the next, the copies form one long shift register. The last copy in the chain first sends its own 64 bits and then the 64-bit slot of each upstream copy, one after another. The longest usable chain is set by the bit-clock limit: copies × 64 × frame rate must not exceed the highest bit-clock frequency the line supports.

The serial output register is clocked on the falling bit-clock edge. A downstream copy or the host can therefore sample it on the rising edge.

Top module: `tdm_chain_serializer`

## Requirements
- R1: While the asynchronous active-low reset is asserted, serialOut is 0. After reset is released, if frameSync and cascadeIn stay 0, serialOut stays 0.
- R2: A rising edge sampled on frameSync loads the register from leftIn and rightIn. The bit-clock edge that samples the first high level of frameSync is the load edge. On the falling edge that follows it, serialOut shows bit WORD_W-1 of leftIn.
- R3: The 64 output slots of a frame, counted from the falling edge after the load edge, carry the bits in a fixed order. Slots 0..31 carry leftIn bits 31 down to 0, and slots 32..63 carry rightIn bits 31 down to 0.
- R4: On each rising edge that does not load, the register shifts toward its most significant end and takes cascadeIn into bit 0. A cascadeIn value sampled on the k-th rising edge after the load edge (k ≥ 1) appears on serialOut in slot 63+k.
- R5: serialOut changes only on falling bit-clock edges. It is stable from just after a rising edge until the next falling edge.
- R6: If frameSync is held high for several bit clocks, the register loads only on the first of them. The following edges shift normally.
- R7: Changes on leftIn and rightIn on edges that do not load have no effect on serialOut.
- R8: A new frameSync rising edge in the middle of a frame has priority over shifting. It reloads the register at once, and the new frame's slot 0 appears on the following falling edge.
- R9: When the serialOut of an upstream copy, loaded on the same frameSync, drives cascadeIn, the downstream serialOut carries the downstream words in slots 0..63 and the upstream words in slots 64..127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock. Loading and shifting happen on the rising edge, output update on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame-sync pulse. A rising level loads the register |
| leftIn | input | WORD_W | Left sample, sent first |
| rightIn | input | WORD_W | Right sample, sent second |
| cascadeIn | input | 1 | Serial fill from the upstream copy |
| serialOut | output | 1 | Serial data toward the next copy or the host |

## Verification
The case hardest to reach from the ports is the exact 64-cycle transit of cascade data. It is only visible in slots 64 and later, after the block's own words have fully left the register. The bench drives a known 64-bit pattern on cascadeIn, bit by bit, starting right after the load edge, and compares slots 64..127 against it. It then repeats the transit with a second instance wired in as the upstream copy. A reload in the middle of a frame and a frame-sync held high for several cycles are forced by timing frameSync against the bench's own slot counter.

// File: rtl/tdmser_pkg.sv
package tdmser_pkg;
  // Strobes issued by control toward the datapath on each rising bit-clock edge
  typedef struct packed {
    logic load;   // copy parallel words into the shift register
    logic shift;  // move one position toward the MSB, fill from cascade
  } serStrobe_t;
endpackage

// File: rtl/tdmser_ctrl.sv
module tdmser_ctrl
  import tdmser_pkg::*;
(
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       frameSync,
  output serStrobe_t strobe
);
  logic fsPrev;
  logic fsRise;

  // Track previous frame-sync level so a long pulse loads only once
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) fsPrev <= 1'b0;
    else       fsPrev <= frameSync;
  end

  assign fsRise = frameSync & ~fsPrev;

  // Load wins over shift on the edge that sees the rising frame sync
  always_comb begin
    strobe.load  = fsRise;
    strobe.shift = ~fsRise;
  end

  // R6: two consecutive load strobes never occur
  a_r6_one_load: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.load |=> !strobe.load);

  // R6: a load only ever happens while the frame-sync port is high
  a_r6_load_needs_fs: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.load |-> frameSync);
endmodule

// File: rtl/tdmser_datapath.sv
module tdmser_datapath
  import tdmser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  input  logic              cascadeIn,
  output logic              serialOut
);
  localparam int FRAME_W = 2 * WORD_W;

  logic [FRAME_W-1:0] shiftReg;
  logic               outQ;

  // Rising edge: parallel load or shift with cascade fill
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= {leftIn, rightIn};
    else if (strobe.shift) shiftReg <= {shiftReg[FRAME_W-2:0], cascadeIn};
  end

  // Falling edge: present MSB so receivers sample it on the rising edge
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) outQ <= 1'b0;
    else       outQ <= shiftReg[FRAME_W-1];
  end

  assign serialOut = outQ;

  // R2: load strobe captures both words
  a_r2_load_capture: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.load |=> shiftReg == {$past(leftIn), $past(rightIn)});

  // R2: left MSB is on the output by the next rising edge
  a_r2_msb_out: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.load |=> serialOut == $past(leftIn[WORD_W-1]));

  // R4: shift moves the word up and takes the cascade bit at the bottom
  a_r4_shift_in: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.shift |=> (shiftReg[0] == $past(cascadeIn)) &&
                     (shiftReg[FRAME_W-1:1] == $past(shiftReg[FRAME_W-2:0])));
endmodule

// File: rtl/tdm_chain_serializer.sv
module tdm_chain_serializer
  import tdmser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  input  logic              cascadeIn,
  output logic              serialOut
);
  serStrobe_t strobe;

  tdmser_ctrl ctrl_i (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .strobe    (strobe)
  );

  tdmser_datapath #(.WORD_W(WORD_W)) dp_i (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .leftIn    (leftIn),
    .rightIn   (rightIn),
    .cascadeIn (cascadeIn),
    .serialOut (serialOut)
  );
endmodule

// File: tb/tdm_chain_serializer_tb_top.sv
module tdm_chain_serializer_tb_top;
  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic [31:0] leftIn = '0, rightIn = '0;
  logic [31:0] upLeft = '0, upRight = '0;
  logic        cascDrive = 1'b0;
  logic        chainMode = 1'b0;
  logic        upOut;
  logic        cascadeIn;
  logic        serialOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          summaryDone = 0;

  always #5 bitClk = ~bitClk;

  assign cascadeIn = chainMode ? upOut : cascDrive;

  tdm_chain_serializer #(.WORD_W(32)) dut_i (
    .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync),
    .leftIn(leftIn), .rightIn(rightIn), .cascadeIn(cascadeIn),
    .serialOut(serialOut));

  tdm_chain_serializer #(.WORD_W(32)) up_i (
    .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync),
    .leftIn(upLeft), .rightIn(upRight), .cascadeIn(1'b0),
    .serialOut(upOut));

  task automatic check(input logic act, input logic exp, input string req, input int slot);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s slot %0d: actual %b expected %b", req, slot, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    end
    $finish;
  endtask

  // One frame of 128 slots. Own words, then cascade data. Checks R3/R4/R5/R6/R7.
  task automatic run_frame(input logic [31:0] l, input logic [31:0] r,
                           input logic [63:0] casc, input int fsLen,
                           input logic [63:0] upWords, input logic chained);
    logic [63:0] own;
    logic [63:0] tail;
    logic        v;
    own  = {l, r};
    tail = chained ? upWords : casc;
    @(negedge bitClk); #1;
    frameSync = 1'b1; leftIn = l; rightIn = r;
    upLeft = upWords[63:32]; upRight = upWords[31:0];
    chainMode = chained; cascDrive = 1'b0;
    for (int k = 0; k < 128; k++) begin
      @(negedge bitClk); #1;
      v = serialOut;
      if (k < 32)      check(v, own[63-k], "R3 left", k);
      else if (k < 64) check(v, own[63-k], "R3 right", k);
      else             check(v, tail[127-k], chained ? "R9 chain" : "R4 cascade", k);
      // Next inputs: fs held per R6, junk words per R7, cascade pattern per R4
      frameSync = (k + 1 < fsLen);
      leftIn  = ~l ^ k; rightIn = r + k + 1;
      cascDrive = (k < 64) ? casc[63-k] : 1'b0;
      @(posedge bitClk); #1;
      check(serialOut, v, "R5 stable", k);
    end
    frameSync = 1'b0; chainMode = 1'b0; cascDrive = 1'b0;
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(posedge bitClk);
    #1 check(serialOut, 1'b0, "R1 in reset", 0);
    @(negedge bitClk); #1 rstN = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge bitClk); #1 check(serialOut, 1'b0, "R1 idle", k);
    end
  endtask

  task automatic test_first_bit();
    @(negedge bitClk); #1;
    frameSync = 1'b1; leftIn = 32'h8000_0001; rightIn = 32'h0;
    @(posedge bitClk); #1 check(serialOut, 1'b0, "R2 before fall", 0);
    @(negedge bitClk); #1 check(serialOut, 1'b1, "R2 left MSB", 0);
    frameSync = 1'b0;
    repeat (70) @(negedge bitClk);
  endtask

  // R8: reload after 10 slots of frame A; frame B starts at once
  task automatic test_reload();
    logic [63:0] a, b;
    a = 64'hF0F0_1234_5678_0F0F;
    b = 64'h1357_9BDF_2468_ACE0;
    @(negedge bitClk); #1;
    frameSync = 1'b1; leftIn = a[63:32]; rightIn = a[31:0]; cascDrive = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge bitClk); #1;
      check(serialOut, a[63-k], "R8 frame A", k);
      frameSync = (k == 9);
      if (k == 9) begin leftIn = b[63:32]; rightIn = b[31:0]; end
    end
    for (int k = 0; k < 64; k++) begin
      @(negedge bitClk); #1;
      check(serialOut, b[63-k], "R8 frame B", k);
      frameSync = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_first_bit();
    run_frame(32'hA5C3_0001, 32'h8000_7FFE, 64'hDEAD_BEEF_0123_4567, 1, 64'h0, 1'b0);
    run_frame(32'h0000_0000, 32'hFFFF_FFFF, 64'hFFFF_0000_AAAA_5555, 1, 64'h0, 1'b0);
    run_frame(32'h1234_5678, 32'h9ABC_DEF0, 64'h8000_0000_0000_0001, 4, 64'h0, 1'b0);
    test_reload();
    run_frame(32'hCAFE_F00D, 32'h0BAD_C0DE, 64'h0, 1, 64'h7766_5544_3322_1100, 1'b1);
    finish_run();
  end
endmodule